// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit

This unit performs the integer multiply and divide operations of a 32-bit RISC-V core: the low-half product, three high-half products that differ only in how the operands are signed, and signed and unsigned quotient and remainder. A core's execute stage pulses `start` with a 3-bit operation code and two operands. It then waits on `busy` until a one-cycle `done` strobe shows that `result` is valid.

By default both families advance one bit per clock. Multiplication uses a shift-and-add loop and division uses a restoring loop. Both run on operand magnitudes, and a closing cycle applies the signs. A build-time switch replaces the multiply loop with a single wide product that is registered at issue. With the switch set, multiplication finishes in one cycle after issue, and division stays bit-serial.

Top module: `mdu_unit`

## Requirements
- R1: Operation code 3'b000 returns the low XLEN bits of the product of the two operands.
- R2: Codes 3'b001, 3'b010 and 3'b011 return the high XLEN bits of the 2*XLEN-bit product. Code 001 treats both operands as signed. Code 010 treats operand A as signed and operand B as unsigned. Code 011 treats both as unsigned.
- R3: Codes 3'b101 and 3'b111 return the unsigned quotient and the unsigned remainder of A divided by B.
- R4: Codes 3'b100 and 3'b110 return the signed quotient, rounded toward zero, and the signed remainder. The quotient is negative when the operand signs differ, and the remainder carries the sign of A.
- R5: When B is zero, the quotient codes return all ones and the remainder codes return A unchanged.
- R6: When A is the most negative value and B is -1, the signed quotient is A and the signed remainder is zero.
- R7: A start accepted on a clock edge is followed by `done` XLEN+1 edges later on the serial path. `busy` is high for every cycle in between.
- R8: With FAST_MUL set, the four multiply codes raise `done` one edge after the accepting edge. Division keeps the XLEN+1 edge latency.
- R9: A `start`, operation code or operand change while `busy` is high has no effect on the running operation, on its result or on its latency.
- R10: After reset, `busy`, `done` and `result` are all zero.
- R11: `done` is high for exactly one cycle. `result` then holds its value until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue pulse, accepted only while idle |
| op | input | 3 | Operation code (see R1 to R5) |
| opA | input | XLEN | First operand (multiplicand or dividend) |
| opB | input | XLEN | Second operand (multiplier or divisor) |
| result | output | XLEN | Registered result of the last operation |
| busy | output | 1 | High from the accepting edge until completion |
| done | output | 1 | One-cycle completion strobe |

## Verification
The in-line properties check the following on every cycle:
- the remainder register stays below a nonzero divisor throughout a division;
- a zero divisor drives the quotient register to all ones;
- the latched operation stays stable while iterating;
- `done` follows a busy cycle and never lasts two cycles;
- the fast path completes one cycle after issue.

Only the bench scenarios can show the actual arithmetic. These are the sign handling of each high-half product, the rounding and sign of signed quotients and remainders, and the divide-by-zero and overflow results. The bench sweeps corner-heavy operand sets on an 8-bit build, both serial and fast, and on the default 32-bit build. It also shows that a start issued mid-operation is ignored.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_MUL    = 3'b000,
    OP_MULH   = 3'b001,
    OP_MULHSU = 3'b010,
    OP_MULHU  = 3'b011,
    OP_DIV    = 3'b100,
    OP_DIVU   = 3'b101,
    OP_REM    = 3'b110,
    OP_REMU   = 3'b111
  } mdu_op_e;

  // strobes from the sequencer to the arithmetic path
  typedef struct packed {
    logic load;    // capture operands, signs and operation
    logic step;    // one iteration of the active loop
    logic finish;  // apply signs and register the result
  } mdu_ctl_t;

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int FAST_MUL = 0
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     isDiv,
  output mdu_ctl_t ctl,
  output logic     busy,
  output logic     done
);

  localparam int CW = (XLEN > 1) ? $clog2(XLEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(XLEN - 1);
  localparam bit FAST = (FAST_MUL != 0);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} state_e;

  state_e        state;
  logic [CW-1:0] cnt;

  always_comb begin
    ctl.load   = start && (state == S_IDLE);
    ctl.step   = (state == S_RUN);
    ctl.finish = (state == S_FIX);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= ctl.finish;
      case (state)
        S_IDLE: if (start) begin
          cnt   <= '0;
          state <= (FAST && !isDiv) ? S_FIX : S_RUN;
        end
        S_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= S_FIX;
        end
        S_FIX:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11
  AST_FAST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (FAST && ctl.load && !isDiv) |=> ctl.finish); // R8
  AST_SERIAL_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && (isDiv || !FAST)) |=> ctl.step); // R7

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int FAST_MUL = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  mdu_ctl_t        ctl,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic [XLEN-1:0] result
);

  localparam int PW = 2 * XLEN;

  mdu_op_e         opIn, opReg;
  logic [XLEN-1:0] hi, lo, dvs, rawA;
  logic            negRes, negRem, divZero;

  // operand conditioning at issue
  logic            aSgn, bSgn;
  logic [XLEN-1:0] aMag, bMag;
  logic [PW-1:0]   fastProd;

  assign opIn = mdu_op_e'(op);

  always_comb begin
    aSgn = opA[XLEN-1] && (opIn == OP_MULH || opIn == OP_MULHSU ||
                           opIn == OP_DIV  || opIn == OP_REM);
    bSgn = opB[XLEN-1] && (opIn == OP_MULH || opIn == OP_DIV || opIn == OP_REM);
    aMag = aSgn ? -opA : opA;
    bMag = bSgn ? -opB : opB;
  end

  generate
    if (FAST_MUL != 0) begin : g_fastMul
      assign fastProd = {{XLEN{1'b0}}, aMag} * {{XLEN{1'b0}}, bMag};
    end else begin : g_serialMul
      assign fastProd = '0;
    end
  endgenerate

  // one iteration of either loop
  logic [XLEN:0]   mulSum, divShift;
  logic [XLEN+1:0] divDiff;
  logic            divOk;

  always_comb begin
    mulSum   = {1'b0, hi} + (lo[0] ? {1'b0, dvs} : '0);
    divShift = {hi, lo[XLEN-1]};
    divDiff  = {1'b0, divShift} - {2'b0, dvs};
    divOk    = !divDiff[XLEN+1];
  end

  // sign fix-up and selection
  logic [PW-1:0]   prodAdj;
  logic [XLEN-1:0] quot, remd, fixVal;

  always_comb begin
    prodAdj = negRes ? -{hi, lo} : {hi, lo};
    quot    = negRes ? -lo : lo;
    remd    = negRem ? -hi : hi;
    case (opReg)
      OP_MUL:                      fixVal = lo;
      OP_MULH, OP_MULHSU, OP_MULHU: fixVal = prodAdj[PW-1:XLEN];
      OP_DIV, OP_DIVU:             fixVal = divZero ? '1 : quot;
      default:                     fixVal = divZero ? rawA : remd;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg   <= OP_MUL;
      hi      <= '0;
      lo      <= '0;
      dvs     <= '0;
      rawA    <= '0;
      negRes  <= 1'b0;
      negRem  <= 1'b0;
      divZero <= 1'b0;
      result  <= '0;
    end else begin
      if (ctl.load) begin
        opReg   <= opIn;
        rawA    <= opA;
        negRes  <= aSgn ^ bSgn;
        negRem  <= aSgn;
        divZero <= (opB == '0);
        if (op[2]) begin
          hi  <= '0;
          lo  <= aMag;
          dvs <= bMag;
        end else if (FAST_MUL != 0) begin
          {hi, lo} <= fastProd;
          dvs      <= aMag;
        end else begin
          hi  <= '0;
          lo  <= bMag;
          dvs <= aMag;
        end
      end else if (ctl.step) begin
        if (opReg[2]) begin
          hi <= divOk ? divDiff[XLEN-1:0] : divShift[XLEN-1:0];
          lo <= {lo[XLEN-2:0], divOk};
        end else begin
          hi <= mulSum[XLEN:1];
          lo <= {mulSum[0], lo[XLEN-1:1]};
        end
      end
      if (ctl.finish) result <= fixVal;
    end
  end

  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ctl.step |=> $stable(opReg)); // R9
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && opReg[2] && dvs != '0) |=> (hi < dvs)); // R3
  AST_ZERO_DIVISOR_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.finish && opReg[2] && divZero) |-> (lo == '1)); // R5

endmodule

// File: rtl/mdu_unit.sv
module mdu_unit
  import mdu_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int FAST_MUL = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  output logic [XLEN-1:0] result,
  output logic            busy,
  output logic            done
);

  mdu_ctl_t ctl;

  mdu_ctrl #(.XLEN(XLEN), .FAST_MUL(FAST_MUL)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .isDiv (op[2]),
    .ctl   (ctl),
    .busy  (busy),
    .done  (done)
  );

  mdu_datapath #(.XLEN(XLEN), .FAST_MUL(FAST_MUL)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .op     (op),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );

endmodule

// File: tb/mdu_unit_test.sv
module mdu_unit_test;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // index 0: 8-bit serial, 1: 8-bit fast multiply, 2: 32-bit serial
  logic        startV [3];
  logic [2:0]  opV    [3];
  logic [31:0] aV     [3];
  logic [31:0] bV     [3];
  logic [31:0] resV   [3];
  logic        busyV  [3];
  logic        doneV  [3];

  logic [7:0]  res0, res1;
  logic [31:0] res2;
  logic        busy0, busy1, busy2, done0, done1, done2;

  mdu_unit #(.XLEN(8), .FAST_MUL(0)) uut (
    .clk(clk), .rstN(rstN), .start(startV[0]), .op(opV[0]),
    .opA(aV[0][7:0]), .opB(bV[0][7:0]), .result(res0), .busy(busy0), .done(done0));

  mdu_unit #(.XLEN(8), .FAST_MUL(1)) uutFast (
    .clk(clk), .rstN(rstN), .start(startV[1]), .op(opV[1]),
    .opA(aV[1][7:0]), .opB(bV[1][7:0]), .result(res1), .busy(busy1), .done(done1));

  mdu_unit #(.XLEN(32), .FAST_MUL(0)) uutWide (
    .clk(clk), .rstN(rstN), .start(startV[2]), .op(opV[2]),
    .opA(aV[2]), .opB(bV[2]), .result(res2), .busy(busy2), .done(done2));

  assign resV[0]  = {24'b0, res0};
  assign resV[1]  = {24'b0, res1};
  assign resV[2]  = res2;
  assign busyV[0] = busy0;
  assign busyV[1] = busy1;
  assign busyV[2] = busy2;
  assign doneV[0] = done0;
  assign doneV[1] = done1;
  assign doneV[2] = done2;

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  // reference arithmetic on a w-bit machine
  function automatic logic [31:0] model(input logic [2:0] f, input logic [31:0] x,
                                        input logic [31:0] y, input int w);
    longint msk = (longint'(1) << w) - 1;
    longint ux = longint'(x) & msk;
    longint uy = longint'(y) & msk;
    longint sx = x[w-1] ? ux - (longint'(1) << w) : ux;
    longint sy = y[w-1] ? uy - (longint'(1) << w) : uy;
    logic signed [127:0] pa, pb, p;
    logic [127:0] pm;
    bit ovf = (sx == -(longint'(1) << (w - 1))) && (sy == -1);
    pa = (f == 3'b001 || f == 3'b010) ? 128'(sx) : 128'(ux);
    pb = (f == 3'b001) ? 128'(sy) : 128'(uy);
    p  = pa * pb;
    pm = 128'(msk);
    case (f)
      3'b000:                 return 32'(p & pm);
      3'b001, 3'b010, 3'b011: return 32'((p >>> w) & pm);
      3'b100: return (uy == 0) ? 32'(msk) : ovf ? 32'(ux) : 32'((sx / sy) & msk);
      3'b101: return (uy == 0) ? 32'(msk) : 32'(ux / uy);
      3'b110: return (uy == 0) ? 32'(ux) : ovf ? 32'(0) : 32'((sx % sy) & msk);
      default: return (uy == 0) ? 32'(ux) : 32'(ux % uy);
    endcase
  endfunction

  function automatic string tagFor(input logic [2:0] f, input logic [31:0] x,
                                   input logic [31:0] y, input int w);
    longint msk = (longint'(1) << w) - 1;
    longint ux = longint'(x) & msk;
    longint uy = longint'(y) & msk;
    if (f == 3'b000) return "R1";
    if (!f[2]) return "R2";
    if (uy == 0) return "R5";
    if (!f[0] && ux == (longint'(1) << (w - 1)) && uy == msk) return "R6";
    return f[0] ? "R3" : "R4";
  endfunction

  // issue one operation and check result, latency, busy and strobe shape
  task automatic runOp(input int idx, input logic [2:0] f, input logic [31:0] x,
                       input logic [31:0] y, input int w, input int lat,
                       input bit ignoreTest);
    int cycles;
    bit busyOk;
    logic [31:0] exp, held;
    string latTag;
    exp = model(f, x, y, w);
    latTag = (idx == 1 && !f[2]) ? "R8" : "R7";
    @(negedge clk);
    opV[idx] = f; aV[idx] = x; bV[idx] = y; startV[idx] = 1'b1;
    @(negedge clk);
    cycles = 1;
    if (ignoreTest) begin
      // R9: different operation presented with start held while busy
      opV[idx] = ~f; aV[idx] = ~x; bV[idx] = x;
    end else begin
      startV[idx] = 1'b0;
    end
    busyOk = 1'b1;
    while (!doneV[idx] && cycles < 200) begin
      if (!busyV[idx]) busyOk = 1'b0;
      @(negedge clk);
      cycles++;
      if (ignoreTest && cycles == 4) startV[idx] = 1'b0;
    end
    check(busyOk, "R7", "busy dropped before done", 0, 1);
    check(cycles - 1 == lat, latTag, "latency", cycles - 1, lat);
    check(resV[idx] == exp, ignoreTest ? "R9" : tagFor(f, x, y, w),
          $sformatf("op=%0d a=%0h b=%0h result", f, x, y), resV[idx], exp);
    held = resV[idx];
    @(negedge clk);
    check(doneV[idx] == 1'b0, "R11", "done width", doneV[idx], 0);
    check(resV[idx] == held, "R11", "result hold", resV[idx], held);
  endtask

  logic [31:0] smallVals [12] = '{32'h00, 32'h01, 32'h02, 32'h03, 32'h07, 32'h7F,
                                  32'h80, 32'h81, 32'hFE, 32'hFF, 32'h55, 32'hC3};
  logic [31:0] wideVals [8]   = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                                  32'h7FFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF, 32'h5};

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      startV[k] = 1'b0; opV[k] = '0; aV[k] = '0; bV[k] = '0;
    end
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check(busyV[k] == 1'b0, "R10", "busy after reset", busyV[k], 0);
      check(doneV[k] == 1'b0, "R10", "done after reset", doneV[k], 0);
      check(resV[k] == 32'h0, "R10", "result after reset", resV[k], 0);
    end
    rstN = 1'b1;

    // R1-style sweep on the serial 8-bit build, every code
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          runOp(0, 3'(f), smallVals[i], smallVals[j], 8, 9, 1'b0);

    // fast multiply build: multiplies in one cycle, division still serial (R8)
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          runOp(1, 3'(f), smallVals[i], smallVals[j], 8, (f < 4) ? 1 : 9, 1'b0);

    // default 32-bit build
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          runOp(2, 3'(f), wideVals[i], wideVals[j], 32, 33, 1'b0);

    // R9: start held and inputs changed while busy
    runOp(0, 3'b100, 32'h64, 32'h07, 8, 9, 1'b1);
    runOp(0, 3'b011, 32'hC3, 32'hFE, 8, 9, 1'b1);
    runOp(2, 3'b110, 32'h8000_0001, 32'h0000_0003, 32, 33, 1'b1);

    summary();
    $finish;
  end

endmodule